// File: doc/BRIEF.md
# Load/Store Access Fault Checker

This block sits beside the load/store stage of a processor pipeline and examines every data access as it goes by. For each valid access it looks at the effective address, the access width, the direction and the register index. It flags two kinds of fault:

- **Misaligned access.** A halfword or word access whose address is not a multiple of its size.
- **Stack bounds violation.** An access that falls outside a programmable stack window. This check runs only while stack checking is switched on.

When a fault is found, the block records the faulting address and an encoded status word in its own registers. It can also issue a one-cycle exception request to the trap logic. The memory interface, address translation and exception vectoring are handled elsewhere.

The status word has a fixed layout:

| Bits | Content |
|------|---------|
| 4:0 | Cause code |
| 9:5 | Register index |
| 10 | Write flag |
| 11 | Word-size flag |

If exceptions are globally disabled, an alignment fault still records its details but does not raise a request. A stack violation always raises one.

Top module: `access_fault_checker`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `faultAddr`, `faultStatus` and `excReq` are zero.
- R2: With `accSize` = 1 (halfword), an access with `accAddr[0]`=1 is an alignment fault. With `accSize` = 2 or 3 (word), an access with `accAddr[1:0]`≠0 is an alignment fault.
- R3: On an alignment fault, `faultStatus` bit 11 is 1 for a word access and 0 for a halfword access.
- R4: On an alignment fault, `faultStatus` holds:
  - cause code 1 in bits 4:0,
  - `accReg` in bits 9:5,
  - `accWrite` in bit 10,
  - zero in all other bits apart from bit 11.
- R5: On any fault, `faultAddr` captures the complete `accAddr`. Registers update on the clock edge that samples `accValid`=1, and `excReq` is high in the cycle that follows.
- R6: With `excEnable`=0, an alignment fault still updates `faultAddr` and `faultStatus`, but `excReq` stays low.
- R7: A byte access (`accSize`=0) never causes an alignment fault.
- R8: With `stackChkEn`=1, an access is a stack violation when `accAddr` < `stackLo` or `accAddr` > `stackHi` (unsigned comparison). Addresses equal to either bound are legal.
- R9: On a stack violation, `faultStatus` becomes cause code 7 with all other bits zero, and `excReq` is raised regardless of `excEnable`.
- R10: With `stackChkEn`=0, no stack violation is reported.
- R11: When an access is both misaligned and out of bounds, the alignment fault is recorded.
- R12: A cycle with no fault (including `accValid`=0) leaves `faultAddr` and `faultStatus` unchanged and drives `excReq` low, so each request lasts one cycle per faulting access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | An access is presented this cycle |
| accAddr | input | ADDR_W | Effective address |
| accWrite | input | 1 | 1 for a store, 0 for a load |
| accReg | input | 5 | Destination or source register index |
| accSize | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| stackLo | input | ADDR_W | Lowest legal stack address |
| stackHi | input | ADDR_W | Highest legal stack address |
| excEnable | input | 1 | Global exception enable |
| stackChkEn | input | 1 | Enables the stack bounds check |
| faultAddr | output | ADDR_W | Address of the last faulting access |
| faultStatus | output | STAT_W | Encoded status of the last fault |
| excReq | output | 1 | One-cycle exception request |

## Verification
Two situations are hard to reach from the ports:

- **Both faults at once.** To reach this, the stack window is programmed and the bench issues a halfword access at an odd address below the window.
- **A silent fault.** This is an alignment fault with exceptions disabled, which records its details but raises no request. The bench makes it observable in two steps. It first loads the status register with a different cause (a stack violation). It then issues the silent fault and confirms that the status register changed while `excReq` stayed low.

// File: rtl/afc_pkg.sv
package afc_pkg;
  localparam int REG_IDX_W = 5;
  localparam int CAUSE_W = 5;
  localparam logic [CAUSE_W-1:0] CAUSE_MISALIGN = 5'd1;
  localparam logic [CAUSE_W-1:0] CAUSE_STACK = 5'd7;
  localparam int REG_LSB = 5;
  localparam int WRITE_BIT = 10;
  localparam int WORD_BIT = 11;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WORD_ALT = 2'd3
  } accSize_e;

  typedef struct packed {
    logic capAlign;
    logic capStack;
    logic isWord;
    logic raise;
  } afcStrobe_t;

  function automatic logic [1:0] sizeMask(input logic [1:0] sz);
    case (sz)
      2'd0: sizeMask = 2'b00;
      2'd1: sizeMask = 2'b01;
      default: sizeMask = 2'b11;
    endcase
  endfunction
endpackage

// File: rtl/afc_ctrl.sv
module afc_ctrl
  import afc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [1:0]        accSize,
  input  logic [ADDR_W-1:0] stackLo,
  input  logic [ADDR_W-1:0] stackHi,
  input  logic              excEnable,
  input  logic              stackChkEn,
  output afcStrobe_t        strobe
);
  logic [1:0] lowMask;
  logic misaligned;
  logic belowLo;
  logic aboveHi;
  logic stackBad;

  always_comb begin
    lowMask = sizeMask(accSize);
    misaligned = |(accAddr[1:0] & lowMask);
    belowLo = accAddr < stackLo;
    aboveHi = accAddr > stackHi;
    stackBad = stackChkEn && (belowLo || aboveHi);
  end

  // Alignment outranks stack protection when both hit.
  always_comb begin
    strobe = '0;
    strobe.isWord = accSize[1];
    if (accValid) begin
      if (misaligned) begin
        strobe.capAlign = 1'b1;
        strobe.raise = excEnable;
      end else if (stackBad) begin
        strobe.capStack = 1'b1;
        strobe.raise = 1'b1;
      end
    end
  end
endmodule

// File: rtl/afc_datapath.sv
module afc_datapath
  import afc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int STAT_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  afcStrobe_t           strobe,
  input  logic [ADDR_W-1:0]    accAddr,
  input  logic                 accWrite,
  input  logic [REG_IDX_W-1:0] accReg,
  output logic [ADDR_W-1:0]    faultAddr,
  output logic [STAT_W-1:0]    faultStatus,
  output logic                 excReq
);
  logic [STAT_W-1:0] alignWord;
  logic [STAT_W-1:0] stackWord;

  always_comb begin
    alignWord = '0;
    alignWord[CAUSE_W-1:0] = CAUSE_MISALIGN;
    alignWord[REG_LSB +: REG_IDX_W] = accReg;
    alignWord[WRITE_BIT] = accWrite;
    alignWord[WORD_BIT] = strobe.isWord;
    stackWord = '0;
    stackWord[CAUSE_W-1:0] = CAUSE_STACK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      faultAddr <= '0;
      faultStatus <= '0;
      excReq <= 1'b0;
    end else begin
      excReq <= strobe.raise;
      if (strobe.capAlign) begin
        faultAddr <= accAddr;
        faultStatus <= alignWord;
      end else if (strobe.capStack) begin
        faultAddr <= accAddr;
        faultStatus <= stackWord;
      end
    end
  end
endmodule

// File: rtl/access_fault_checker.sv
module access_fault_checker
  import afc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int STAT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accWrite,
  input  logic [4:0]        accReg,
  input  logic [1:0]        accSize,
  input  logic [ADDR_W-1:0] stackLo,
  input  logic [ADDR_W-1:0] stackHi,
  input  logic              excEnable,
  input  logic              stackChkEn,
  output logic [ADDR_W-1:0] faultAddr,
  output logic [STAT_W-1:0] faultStatus,
  output logic              excReq
);
  afcStrobe_t strobe;

  afc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .accValid(accValid), .accAddr(accAddr), .accSize(accSize),
    .stackLo(stackLo), .stackHi(stackHi), .excEnable(excEnable),
    .stackChkEn(stackChkEn), .strobe(strobe)
  );

  afc_datapath #(.ADDR_W(ADDR_W), .STAT_W(STAT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .accAddr(accAddr),
    .accWrite(accWrite), .accReg(accReg), .faultAddr(faultAddr),
    .faultStatus(faultStatus), .excReq(excReq)
  );
endmodule

// File: rtl/afc_checker.sv
module afc_checker #(
  parameter int ADDR_W = 32,
  parameter int STAT_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              accValid,
  input logic [ADDR_W-1:0] accAddr,
  input logic [1:0]        accSize,
  input logic [ADDR_W-1:0] stackLo,
  input logic              excEnable,
  input logic              stackChkEn,
  input logic [ADDR_W-1:0] faultAddr,
  input logic [STAT_W-1:0] faultStatus,
  input logic              excReq
);
  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accValid |=> (!excReq && $stable(faultAddr) && $stable(faultStatus)));

  // R3
  word_misalign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accValid && accSize[1] && accAddr[1:0] != 2'b00) |=>
      (faultStatus[11] && faultStatus[4:0] == 5'd1 && faultAddr == $past(accAddr)));

  // R7
  byte_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accValid && accSize == 2'd0 && !stackChkEn) |=> (!excReq && $stable(faultStatus)));

  // R6
  masked_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accValid && !excEnable && !stackChkEn) |=> !excReq);

  // R9
  stack_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accValid && stackChkEn && accSize == 2'd0 && accAddr < stackLo) |=>
      (excReq && faultStatus[4:0] == 5'd7));
endmodule

bind access_fault_checker afc_checker #(.ADDR_W(ADDR_W), .STAT_W(STAT_W)) u_afc_chk (
  .clk(clk), .rst_n(rst_n), .accValid(accValid), .accAddr(accAddr),
  .accSize(accSize), .stackLo(stackLo), .excEnable(excEnable),
  .stackChkEn(stackChkEn), .faultAddr(faultAddr), .faultStatus(faultStatus),
  .excReq(excReq)
);

// File: tb/access_fault_checker_tb.sv
module access_fault_checker_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic accValid = 1'b0;
  logic [31:0] accAddr = '0;
  logic accWrite = 1'b0;
  logic [4:0] accReg = '0;
  logic [1:0] accSize = '0;
  logic [31:0] stackLo = '0;
  logic [31:0] stackHi = 32'hFFFF_FFFF;
  logic excEnable = 1'b0;
  logic stackChkEn = 1'b0;
  logic [31:0] faultAddr;
  logic [31:0] faultStatus;
  logic excReq;
  int nChecks = 0;
  int nFails = 0;

  always #2 clk = ~clk;

  access_fault_checker u_dut (
    .clk(clk), .rst_n(rst_n), .accValid(accValid), .accAddr(accAddr),
    .accWrite(accWrite), .accReg(accReg), .accSize(accSize),
    .stackLo(stackLo), .stackHi(stackHi), .excEnable(excEnable),
    .stackChkEn(stackChkEn), .faultAddr(faultAddr),
    .faultStatus(faultStatus), .excReq(excReq)
  );

  function automatic logic [31:0] alignStat(input logic wr, input logic [4:0] rg,
                                            input logic word);
    alignStat = 32'd1 | (32'(rg) << 5) | (32'(wr) << 10) | (32'(word) << 11);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One access, then sample the registered result at the next falling edge.
  task automatic access(input logic [31:0] a, input logic wr, input logic [4:0] rg,
                        input logic [1:0] sz);
    @(negedge clk);
    accValid = 1'b1; accAddr = a; accWrite = wr; accReg = rg; accSize = sz;
    @(negedge clk);
    accValid = 1'b0;
  endtask

  task automatic tReset();
    check("R1 addr", faultAddr, 32'h0);
    check("R1 status", faultStatus, 32'h0);
    check("R1 req", 32'(excReq), 32'h0);
  endtask

  task automatic tHalf();
    excEnable = 1'b1;
    access(32'h0000_1001, 1'b0, 5'd3, 2'd1);
    check("R2 R4 half status", faultStatus, alignStat(1'b0, 5'd3, 1'b0));
    check("R5 half addr", faultAddr, 32'h0000_1001);
    check("R5 req", 32'(excReq), 32'h1);
    @(negedge clk);
    check("R12 req drops", 32'(excReq), 32'h0);
    check("R12 hold", faultStatus, alignStat(1'b0, 5'd3, 1'b0));
  endtask

  task automatic tWord();
    access(32'h8000_2002, 1'b1, 5'd31, 2'd2);
    check("R3 R4 word status", faultStatus, alignStat(1'b1, 5'd31, 1'b1));
    check("R5 word addr", faultAddr, 32'h8000_2002);
    access(32'h0000_3003, 1'b0, 5'd9, 2'd3);
    check("R3 word alt status", faultStatus, alignStat(1'b0, 5'd9, 1'b1));
    access(32'h0000_4002, 1'b1, 5'd4, 2'd1);
    check("R2 aligned half no req", 32'(excReq), 32'h0);
    check("R2 aligned half hold", faultAddr, 32'h0000_3003);
  endtask

  task automatic tByte();
    access(32'h0000_5003, 1'b0, 5'd1, 2'd0);
    check("R7 byte no req", 32'(excReq), 32'h0);
    check("R7 byte hold", faultStatus, alignStat(1'b0, 5'd9, 1'b1));
  endtask

  task automatic tStack();
    stackLo = 32'h100; stackHi = 32'h1FF; stackChkEn = 1'b1;
    access(32'h0FF, 1'b0, 5'd2, 2'd0);
    check("R8 R9 below status", faultStatus, 32'd7);
    check("R9 below req", 32'(excReq), 32'h1);
    check("R8 below addr", faultAddr, 32'h0FF);
    access(32'h100, 1'b1, 5'd2, 2'd2);
    check("R8 lo edge no req", 32'(excReq), 32'h0);
    access(32'h1FF, 1'b0, 5'd2, 2'd0);
    check("R8 hi edge no req", 32'(excReq), 32'h0);
    check("R8 hi edge hold", faultAddr, 32'h0FF);
    excEnable = 1'b0;
    access(32'h200, 1'b0, 5'd2, 2'd0);
    check("R9 above req w/o enable", 32'(excReq), 32'h1);
    check("R8 above addr", faultAddr, 32'h200);
  endtask

  task automatic tMasked();
    // status currently holds the stack cause
    access(32'h0000_0151, 1'b1, 5'd17, 2'd1);
    check("R6 status updated", faultStatus, alignStat(1'b1, 5'd17, 1'b0));
    check("R6 addr updated", faultAddr, 32'h0000_0151);
    check("R6 no req", 32'(excReq), 32'h0);
    excEnable = 1'b1;
  endtask

  task automatic tPriority();
    access(32'h0000_0011, 1'b0, 5'd6, 2'd1);
    check("R11 align wins", faultStatus, alignStat(1'b0, 5'd6, 1'b0));
    check("R11 req", 32'(excReq), 32'h1);
  endtask

  task automatic tNoStack();
    stackChkEn = 1'b0;
    access(32'h0000_0050, 1'b0, 5'd0, 2'd0);
    check("R10 no req", 32'(excReq), 32'h0);
    check("R10 hold", faultAddr, 32'h0000_0011);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rst_n = 1'b1;
    @(negedge clk);
    tReset();
    tHalf();
    tWord();
    tByte();
    tStack();
    tMasked();
    tPriority();
    tNoStack();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule